// File: doc/BRIEF.md
# Configurable Input Capture Front End

This block conditions the signals that arrive from the device pins before they reach a programmable logic array. It holds two banks: one for the dedicated input pins and one for the pins that double as inputs and outputs. Each bank has a single two-bit mode field that sets every bit of that bank at once. The three modes are direct pass-through, a transparent latch and an edge-triggered flip-flop. The two banks take their modes independently of each other.

One capture clock serves both banks. In latch mode it is the gate, and the latch is open while the clock is high. In register mode its rising edge samples the pins. A preload input forces a chosen value into every storage element so that a test can set up any state, and it overrides the pin value. A synchronous active-low reset clears the storage. The code that no valid mode uses falls back to pass-through and raises an error flag for that bank.

Top module: `icap_front`

## Requirements
- R1: Each bank's mode field is decoded as 2'b00 pass-through, 2'b01 register, 2'b10 latch and 2'b11 invalid. A bank's field applies to every bit of that bank.
- R2: In pass-through mode a bank's output equals its pin input at all times, with no dependence on the capture clock.
- R3: In register mode a bank's output takes the pin value present at each rising edge of the capture clock and holds it until the next rising edge.
- R4: In latch mode a bank's output follows its pins while the capture clock is high. While the clock is low it holds the value that was present when the clock fell.
- R5: With code 2'b11 a bank behaves as in pass-through mode and its error flag is 1. For the three valid codes the flag is 0.
- R6: While preload_en is 1, the bank's preload value replaces the pin value as the data that the flip-flops capture at a rising edge and that the open latches pass.
- R7: rst_n low at a rising edge clears every flip-flop to 0. rst_n low while the clock is high clears every latch to 0. Reset takes priority over preload.
- R8: The two banks are independent. One bank's mode does not change the behaviour of the other bank.
- R9: The flip-flops and latches keep capturing whatever the selected mode is. A value preloaded while a bank is in pass-through mode therefore appears at the output once the bank is switched to latch mode with the clock low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cap_clk | input | 1 | Capture clock: latch gate (active high) and flip-flop clock |
| rst_n | input | 1 | Synchronous active-low reset of the storage |
| ded_cfg | input | 2 | Mode field of the dedicated-input bank |
| io_cfg | input | 2 | Mode field of the I/O-feedback bank |
| ded_pins | input | DED_W | Dedicated input pins |
| io_pins | input | IO_W | I/O feedback pins |
| pre_en | input | 1 | Preload enable for both banks |
| ded_pre | input | DED_W | Preload value for the dedicated bank |
| io_pre | input | IO_W | Preload value for the I/O bank |
| ded_arr | output | DED_W | Conditioned dedicated inputs to the array |
| io_arr | output | IO_W | Conditioned I/O inputs to the array |
| ded_cfg_err | output | 1 | Invalid mode code on the dedicated bank |
| io_cfg_err | output | 1 | Invalid mode code on the I/O bank |

## Verification
The assertions are evaluated at every rising clock edge. They check that pass-through and the invalid code follow the pins, that register mode shows the data or preload value sampled at the previous edge, and that the first edge after reset leaves register outputs at zero. Latch behaviour is not covered by the assertions. Transparency while the clock is high and hold while it is low can only be seen at sample points in the middle of each clock phase, so the bench scenarios check them. The bench also covers mode switches that expose storage filled earlier in pass-through mode, and the independence of the two banks under mixed modes.

// File: rtl/icap_pkg.sv
`timescale 1ns/1ps
// Package: shared mode type for the input capture front end.
// Assumes a two-bit mode field per bank: bit 1 picks the latch, bit 0 picks the register.
package icap_pkg;

    typedef enum logic [1:0] {
        CAP_PASS  = 2'd0,
        CAP_FLOP  = 2'd1,
        CAP_LATCH = 2'd2
    } cap_mode_e;

    localparam logic [1:0] CFG_PASS    = 2'b00;
    localparam logic [1:0] CFG_FLOP    = 2'b01;
    localparam logic [1:0] CFG_LATCH   = 2'b10;
    localparam logic [1:0] CFG_INVALID = 2'b11;

endpackage

// File: rtl/icap_mode_decode.sv
`timescale 1ns/1ps
// Module: icap_mode_decode
// Turns one bank's raw two-bit mode field into a capture mode and an error flag.
// Assumes the field is static or changes only while the capture clock is low.
// The invalid code maps to pass-through so the array never sees stale storage.
module icap_mode_decode
    import icap_pkg::*;
(
    input  logic [1:0] cfg,
    output cap_mode_e  mode,
    output logic       cfg_err
);

    // Map the field onto a mode; the unused code falls back to pass-through.
    always_comb begin
        cfg_err = 1'b0;
        case (cfg)
            CFG_PASS:  mode = CAP_PASS;
            CFG_FLOP:  mode = CAP_FLOP;
            CFG_LATCH: mode = CAP_LATCH;
            default: begin
                mode    = CAP_PASS;
                cfg_err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/icap_cell.sv
`timescale 1ns/1ps
// Module: icap_cell
// One bit of conditioning: a flip-flop and an active-high latch share the capture clock.
// Both always capture, whatever the mode; the mode only picks what reaches the output.
// Assumes synchronous active-low reset: it acts at a rising edge for the flop and
// while the gate is open for the latch.
module icap_cell
    import icap_pkg::*;
(
    input  logic      cap_clk,
    input  logic      rst_n,
    input  logic      pin,
    input  logic      pre_en,
    input  logic      pre_val,
    input  cap_mode_e mode,
    output logic      q
);

    logic next_d;
    logic flop_q;
    logic latch_q;

    // Preload overrides the pin as the captured data.
    assign next_d = pre_en ? pre_val : pin;

    // Edge-triggered capture with synchronous clear.
    always_ff @(posedge cap_clk) begin
        if (!rst_n) flop_q <= 1'b0;
        else        flop_q <= next_d;
    end

    // Transparent while the capture clock is high; clear only while open.
    always_latch begin
        if (cap_clk) begin
            if (!rst_n) latch_q <= 1'b0;
            else        latch_q <= next_d;
        end
    end

    // Output select by bank mode.
    always_comb begin
        case (mode)
            CAP_FLOP:  q = flop_q;
            CAP_LATCH: q = latch_q;
            default:   q = pin;
        endcase
    end

endmodule

// File: rtl/icap_bank.sv
`timescale 1ns/1ps
// Module: icap_bank
// One block-configured bank of WIDTH capture cells sharing a mode field.
// Assumes all cells of the bank share the capture clock, reset and preload enable.
module icap_bank
    import icap_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             cap_clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg,
    input  logic [WIDTH-1:0] pins,
    input  logic             pre_en,
    input  logic [WIDTH-1:0] pre_val,
    output logic [WIDTH-1:0] arr,
    output logic             cfg_err
);

    cap_mode_e mode;

    // Decode the shared mode field once for the bank.
    icap_mode_decode u_dec (
        .cfg     (cfg),
        .mode    (mode),
        .cfg_err (cfg_err)
    );

    // Replicate one cell per bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_cell
        icap_cell u_cell (
            .cap_clk (cap_clk),
            .rst_n   (rst_n),
            .pin     (pins[b]),
            .pre_en  (pre_en),
            .pre_val (pre_val[b]),
            .mode    (mode),
            .q       (arr[b])
        );
    end

endmodule

// File: rtl/icap_front.sv
`timescale 1ns/1ps
// Module: icap_front
// Input capture front end: a dedicated-input bank and an I/O-feedback bank.
// Each bank has its own mode field; the capture clock, reset and preload enable are shared.
// Assumes mode fields change only while cap_clk is low.
module icap_front #(
    parameter int DED_W = 10,
    parameter int IO_W  = 10
) (
    input  logic             cap_clk,
    input  logic             rst_n,
    input  logic [1:0]       ded_cfg,
    input  logic [1:0]       io_cfg,
    input  logic [DED_W-1:0] ded_pins,
    input  logic [IO_W-1:0]  io_pins,
    input  logic             pre_en,
    input  logic [DED_W-1:0] ded_pre,
    input  logic [IO_W-1:0]  io_pre,
    output logic [DED_W-1:0] ded_arr,
    output logic [IO_W-1:0]  io_arr,
    output logic             ded_cfg_err,
    output logic             io_cfg_err
);

    // Dedicated-input bank.
    icap_bank #(.WIDTH(DED_W)) u_ded (
        .cap_clk (cap_clk),
        .rst_n   (rst_n),
        .cfg     (ded_cfg),
        .pins    (ded_pins),
        .pre_en  (pre_en),
        .pre_val (ded_pre),
        .arr     (ded_arr),
        .cfg_err (ded_cfg_err)
    );

    // I/O-feedback bank.
    icap_bank #(.WIDTH(IO_W)) u_io (
        .cap_clk (cap_clk),
        .rst_n   (rst_n),
        .cfg     (io_cfg),
        .pins    (io_pins),
        .pre_en  (pre_en),
        .pre_val (io_pre),
        .arr     (io_arr),
        .cfg_err (io_cfg_err)
    );

endmodule

// File: rtl/icap_front_chk.sv
`timescale 1ns/1ps
// Module: icap_front_chk
// Assertion checker for icap_front, bound to every instance of it.
// Observes only the top-level ports; latch behaviour is left to the bench.
module icap_front_chk #(
    parameter int DED_W = 10,
    parameter int IO_W  = 10
) (
    input logic             cap_clk,
    input logic             rst_n,
    input logic [1:0]       ded_cfg,
    input logic [1:0]       io_cfg,
    input logic [DED_W-1:0] ded_pins,
    input logic [IO_W-1:0]  io_pins,
    input logic             pre_en,
    input logic [DED_W-1:0] ded_pre,
    input logic [IO_W-1:0]  io_pre,
    input logic [DED_W-1:0] ded_arr,
    input logic [IO_W-1:0]  io_arr,
    input logic             ded_cfg_err,
    input logic             io_cfg_err
);

    // R2: pass-through follows the pins
    p_ded_async_follow_r2: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (ded_cfg == 2'b00) |-> (ded_arr == ded_pins));
    p_io_async_follow_r2: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (io_cfg == 2'b00) |-> (io_arr == io_pins));

    // R5: the invalid code falls back to the pins and the flag is raised
    p_ded_invalid_fallback_r5: assert property (@(posedge cap_clk) disable iff (!rst_n)
        ded_cfg_err |-> (ded_arr == ded_pins));
    p_io_invalid_fallback_r5: assert property (@(posedge cap_clk) disable iff (!rst_n)
        io_cfg_err |-> (io_arr == io_pins));

    // R3: register mode shows the pins sampled at the previous edge
    p_ded_reg_capture_r3: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (ded_cfg == 2'b01 && $past(rst_n) && !$past(pre_en)) |-> (ded_arr == $past(ded_pins)));
    p_io_reg_capture_r3: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (io_cfg == 2'b01 && $past(rst_n) && !$past(pre_en)) |-> (io_arr == $past(io_pins)));

    // R6: preload replaces the pins at the edge
    p_ded_preload_flop_r6: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (ded_cfg == 2'b01 && $past(rst_n) && $past(pre_en)) |-> (ded_arr == $past(ded_pre)));
    p_io_preload_flop_r6: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (io_cfg == 2'b01 && $past(rst_n) && $past(pre_en)) |-> (io_arr == $past(io_pre)));

    // R7: the edge after reset leaves register outputs cleared
    p_ded_reset_clear_r7: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (ded_cfg == 2'b01 && !$past(rst_n)) |-> (ded_arr == '0));
    p_io_reset_clear_r7: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (io_cfg == 2'b01 && !$past(rst_n)) |-> (io_arr == '0));

endmodule

bind icap_front icap_front_chk #(.DED_W(DED_W), .IO_W(IO_W)) u_chk (
    .cap_clk     (cap_clk),
    .rst_n       (rst_n),
    .ded_cfg     (ded_cfg),
    .io_cfg      (io_cfg),
    .ded_pins    (ded_pins),
    .io_pins     (io_pins),
    .pre_en      (pre_en),
    .ded_pre     (ded_pre),
    .io_pre      (io_pre),
    .ded_arr     (ded_arr),
    .io_arr      (io_arr),
    .ded_cfg_err (ded_cfg_err),
    .io_cfg_err  (io_cfg_err)
);

// File: tb/icap_front_test.sv
`timescale 1ns/1ps
// Bench: icap_front_test
// Directed corner cases followed by seeded random stimulus, checked against a bench model.
module icap_front_test;

    localparam int DW = 10;
    localparam int IW = 10;

    logic          cap_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic [1:0]    ded_cfg = 2'b01;
    logic [1:0]    io_cfg  = 2'b01;
    logic [DW-1:0] ded_pins = '0;
    logic [IW-1:0] io_pins  = '0;
    logic          pre_en  = 1'b0;
    logic [DW-1:0] ded_pre = '0;
    logic [IW-1:0] io_pre  = '0;
    logic [DW-1:0] ded_arr;
    logic [IW-1:0] io_arr;
    logic          ded_cfg_err;
    logic          io_cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    icap_front #(.DED_W(DW), .IO_W(IW)) uut (
        .cap_clk     (cap_clk),
        .rst_n       (rst_n),
        .ded_cfg     (ded_cfg),
        .io_cfg      (io_cfg),
        .ded_pins    (ded_pins),
        .io_pins     (io_pins),
        .pre_en      (pre_en),
        .ded_pre     (ded_pre),
        .io_pre      (io_pre),
        .ded_arr     (ded_arr),
        .io_arr      (io_arr),
        .ded_cfg_err (ded_cfg_err),
        .io_cfg_err  (io_cfg_err)
    );

    // 125 MHz capture clock.
    always #4 cap_clk = ~cap_clk;

    // Reference storage built from the requirements.
    logic [DW-1:0] m_ded_f = '0, m_ded_l = '0;
    logic [IW-1:0] m_io_f  = '0, m_io_l  = '0;

    always @(posedge cap_clk) begin
        m_ded_f <= !rst_n ? '0 : (pre_en ? ded_pre : ded_pins);
        m_io_f  <= !rst_n ? '0 : (pre_en ? io_pre  : io_pins);
    end

    always @(negedge cap_clk) begin
        m_ded_l <= !rst_n ? '0 : (pre_en ? ded_pre : ded_pins);
        m_io_l  <= !rst_n ? '0 : (pre_en ? io_pre  : io_pins);
    end

    function automatic logic [31:0] exp_out(input logic [1:0] cfg, input logic [31:0] pins,
                                            input logic [31:0] f, input logic [31:0] l,
                                            input logic [31:0] pv);
        case (cfg)
            2'b01:   return f;
            2'b10:   return cap_clk ? (!rst_n ? 32'd0 : (pre_en ? pv : pins)) : l;
            default: return pins;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] cfg);
        case (cfg)
            2'b00:   return "R1/R2";
            2'b01:   return "R1/R3";
            2'b10:   return "R1/R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    task automatic check_all();
        chk({tag_of(ded_cfg), " ded"}, 32'(ded_arr),
            exp_out(ded_cfg, 32'(ded_pins), 32'(m_ded_f), 32'(m_ded_l), 32'(ded_pre)));
        chk({tag_of(io_cfg), " io"}, 32'(io_arr),
            exp_out(io_cfg, 32'(io_pins), 32'(m_io_f), 32'(m_io_l), 32'(io_pre)));
        chk("R5 ded flag", 32'(ded_cfg_err), 32'(ded_cfg == 2'b11));
        chk("R5 io flag",  32'(io_cfg_err),  32'(io_cfg == 2'b11));
    endtask

    // One clock of stimulus: drive in the low phase, change the pins again in the high phase.
    task automatic step(input logic [1:0] dc, input logic [1:0] ic, input logic pe,
                        input logic [DW-1:0] dp, input logic [IW-1:0] ip,
                        input logic [DW-1:0] dv, input logic [IW-1:0] iv,
                        input logic [DW-1:0] dp2, input logic [IW-1:0] ip2);
        @(negedge cap_clk); #1;
        ded_cfg = dc; io_cfg = ic; pre_en = pe;
        ded_pins = dp; io_pins = ip; ded_pre = dv; io_pre = iv;
        #1 check_all();
        @(posedge cap_clk); #1 check_all();
        #1 ded_pins = dp2; io_pins = ip2;
        #1 check_all();
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));

        // R7: reset clears the register-mode outputs
        repeat (3) @(posedge cap_clk);
        @(negedge cap_clk); #1;
        chk("R7 ded reset", 32'(ded_arr), 32'd0);
        chk("R7 io reset",  32'(io_arr),  32'd0);
        rst_n = 1'b1;

        // R3: capture and hold between edges
        step(2'b01, 2'b01, 1'b0, 10'h2A5, 10'h15A, '0, '0, 10'h3FF, 10'h000);

        // R4: latch transparent while high, holding while low
        step(2'b10, 2'b10, 1'b0, 10'h0F0, 10'h30C, '0, '0, 10'h111, 10'h222);
        @(negedge cap_clk); #1 ded_pins = 10'h3C3; io_pins = 10'h0AA;
        #1;
        chk("R4 ded hold", 32'(ded_arr), 32'h111);
        chk("R4 io hold",  32'(io_arr),  32'h222);

        // R8: one bank registers, the other passes through
        step(2'b01, 2'b00, 1'b0, 10'h155, 10'h2AA, '0, '0, 10'h001, 10'h3F0);
        chk("R8 ded holds", 32'(ded_arr), 32'h155);
        chk("R8 io follows", 32'(io_arr), 32'h3F0);

        // R5: invalid code behaves as pass-through with the flag set
        step(2'b11, 2'b10, 1'b0, 10'h321, 10'h123, '0, '0, 10'h0DE, 10'h0AD);
        chk("R5 ded follows", 32'(ded_arr), 32'h0DE);

        // R9 and R6: preload while in pass-through, then reveal through the latch
        step(2'b00, 2'b00, 1'b1, 10'h000, 10'h3FF, 10'h2B4, 10'h14B, 10'h001, 10'h002);
        @(negedge cap_clk); #1 pre_en = 1'b0; ded_cfg = 2'b10; io_cfg = 2'b10;
        #1;
        chk("R9 ded preload via latch", 32'(ded_arr), 32'h2B4);
        chk("R9 io preload via latch",  32'(io_arr),  32'h14B);

        // R7: reset has priority over preload
        rst_n = 1'b0; pre_en = 1'b1; ded_cfg = 2'b01; io_cfg = 2'b01;
        @(posedge cap_clk); #1;
        chk("R7 ded reset over preload", 32'(ded_arr), 32'd0);
        chk("R7 io reset over preload",  32'(io_arr),  32'd0);
        @(negedge cap_clk); #1 rst_n = 1'b1; pre_en = 1'b0;

        // Seeded random mix of modes, pins and preload.
        for (int i = 0; i < 400; i++) begin
            step(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 7) == 0),
                 DW'($urandom), IW'($urandom), DW'($urandom), IW'($urandom),
                 DW'($urandom), IW'($urandom));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule